// File: doc/BRIEF.md
# Parallel ATA programmed-I/O host cycle engine

This block lets a processor talk to a parallel ATA device in True IDE mode without bit-banging the bus. Software sees a small 32-bit register space holding an enable, a configuration word, a packed timing word, an interrupt status/mask pair and the nine task-file windows. A write to a task-file window becomes one device write cycle. A read of a task-file window only launches a device read cycle. The captured word is fetched later from a separate read-data register. A pending word tells software when the engine and its one-entry holding slot have drained.

Each device cycle walks through three phases. In the setup phase the chip select and the 3-bit device address are driven. In the strobe phase DIOR or DIOW is asserted, and the phase is stretched while IORDY is low if wait states are enabled. In the recovery phase the strobe is released while address and select stay put. All three phase lengths come from the timing word and are counted in controller clocks. A rising edge on the device interrupt line is synchronised and latched into a status bit that can be masked.

The request side is a valid/ready channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low only when the request targets a task-file window and the holding slot is occupied. Requests to other registers are never stalled. Every accepted read returns exactly one `rsp_valid` pulse on the following cycle. There is no back-pressure on responses.

Top module: `pata_pio_host`

## Requirements
- R1: After reset all chip selects and strobes are deasserted (high), `ata_dd_oe` is low, `irq` is low, `req_ready` is high, and every readable register returns zero.
- R2: A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is low exactly when the request addresses a task-file window and the holding slot is full. An accepted read yields `rsp_valid` with its data one cycle later.
- R3: Task-file windows map to device selects as follows. Offsets 0x54, 0x58, 0x5C, 0x60, 0x64, 0x68, 0x6C and 0x70 drive chip select 0 low with device address 0 to 7. Offset 0x74 drives chip select 1 low with device address 6. Address and select stay stable from setup through recovery and return to 0 / high when idle.
- R4: The timing register at 0x2C holds setup in bits [3:0], strobe in bits [11:4] and recovery in bits [19:12]. Each phase lasts that many clocks, and a zero field counts as one. The values are sampled when a cycle launches.
- R5: With configuration bit 1 (offset 0x18) set at launch, the strobe phase is held past its count for as long as `ata_iordy` is low. With the bit clear, `ata_iordy` has no effect.
- R6: In a write cycle the device bus is driven with `ata_dd_oe` high from setup to the end of recovery. A task-file write drives the low byte with the upper byte zero. A data-window (0x54) write drives all 16 bits, with the bytes swapped when configuration bit 6 was set at acceptance.
- R7: A read cycle captures the device bus on the edge that ends the strobe. Register 0x7C then returns the low byte (upper bits zero) for a task-file window, or the full 16-bit word (byte-swapped if configuration bit 6 was set at acceptance) for the data window. A task-file read itself returns zero.
- R8: No cycle launches while control bit 0 (offset 0x00) is clear. An access already held waits and launches once the bit is set.
- R9: Register 0x84 reads bit 28 = engine busy and bit 29 = holding slot occupied, with all other bits zero. The value is zero exactly when the next access can start at once.
- R10: An access waiting in the holding slot launches on the very edge that ends the current recovery, with no idle cycle between the two cycles.
- R11: A rising edge of `ata_intrq`, after a two-flop synchroniser, sets status bit 0 at 0x10. Writing 1 to that bit clears it, and a set in the same cycle wins. `irq` is status bit 0 AND mask bit 0 (offset 0x14).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response strobe, one cycle after an accepted read |
| rsp_data | output | 32 | Read response data |
| ata_cs0_n | output | 1 | Device chip select 0, active low |
| ata_cs1_n | output | 1 | Device chip select 1, active low |
| ata_da | output | 3 | Device register address |
| ata_dior_n | output | 1 | Device read strobe, active low |
| ata_diow_n | output | 1 | Device write strobe, active low |
| ata_dd_out | output | 16 | Device data bus, outgoing |
| ata_dd_oe | output | 1 | Device data bus output enable |
| ata_dd_in | input | 16 | Device data bus, incoming |
| ata_iordy | input | 1 | Device ready for wait-state insertion |
| ata_intrq | input | 1 | Device interrupt request |
| irq | output | 1 | Masked interrupt output |

## Verification
A wrong phase counter or a stale latched timing shows up on `ata_dior_n`/`ata_diow_n` or on the chip selects within the same cycle it goes wrong. This is because the bench model predicts every device pin on every clock. A lost or duplicated holding-slot entry appears as a missing or extra strobe, or as a wrong `req_ready`, on the very next cycle. A corrupted capture or byte lane stays hidden until software reads 0x7C. The bench therefore reads back after every read cycle and checks the pending word and interrupt output directly.

// File: rtl/pata_pio_pkg.sv
package pata_pio_pkg;
  localparam int REG_AW = 8;
  localparam int REG_DW = 32;
  localparam int DEV_DW = 16;
  localparam int DEV_AW = 3;
  localparam int SET_W  = 4;
  localparam int ACT_W  = 8;
  localparam int REC_W  = 8;
  localparam int TIME_W = SET_W + ACT_W + REC_W;
  localparam int CNT_W  = 8;

  localparam logic [REG_AW-1:0] OFS_CTRL  = 8'h00;
  localparam logic [REG_AW-1:0] OFS_ISTAT = 8'h10;
  localparam logic [REG_AW-1:0] OFS_IMASK = 8'h14;
  localparam logic [REG_AW-1:0] OFS_CFG   = 8'h18;
  localparam logic [REG_AW-1:0] OFS_TIME  = 8'h2C;
  localparam logic [REG_AW-1:0] OFS_TF_LO = 8'h54;
  localparam logic [REG_AW-1:0] OFS_TF_HI = 8'h74;
  localparam logic [REG_AW-1:0] OFS_RDATA = 8'h7C;
  localparam logic [REG_AW-1:0] OFS_PEND  = 8'h84;

  localparam int CFG_WAIT_BIT = 1;
  localparam int CFG_SWAP_BIT = 6;
  localparam int PEND_BUSY_BIT = 28;
  localparam int PEND_SLOT_BIT = 29;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_RECOV} phase_t;

  typedef struct packed {
    logic              wr;
    logic              cs1;
    logic [DEV_AW-1:0] da;
    logic              wide;
    logic              swap;
    logic [DEV_DW-1:0] data;
  } dev_op_t;

  function automatic logic [DEV_DW-1:0] swap_bytes(input logic [DEV_DW-1:0] w);
    return {w[DEV_DW/2-1:0], w[DEV_DW-1:DEV_DW/2]};
  endfunction
endpackage

// File: rtl/pata_pio_regs.sv
module pata_pio_regs
  import pata_pio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [REG_AW-1:0] req_addr,
  input  logic [REG_DW-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [REG_DW-1:0] rsp_data,
  input  logic              slot_full,
  output logic              push,
  output dev_op_t           push_op,
  output logic              ctrl_en,
  output logic              cfg_wait,
  output logic [TIME_W-1:0] timing,
  input  logic              busy,
  input  logic              cap_fire,
  input  logic [DEV_DW-1:0] cap_word,
  input  logic              intrq,
  output logic              irq
);
  logic              en_q, wait_q, swap_q, mask_q, stat_q;
  logic [TIME_W-1:0] time_q;
  logic [DEV_DW-1:0] rdcap_q;
  logic [SYNC_STAGES:0] sync_q;
  logic              tf_hit, accept, clr_stat, intr_edge;
  logic [REG_AW-1:0] tf_off;
  logic [REG_AW-3:0] tf_idx;
  logic [REG_DW-1:0] rd_val;
  logic              unused_wdata;

  assign tf_off = req_addr - OFS_TF_LO;
  assign tf_idx = tf_off[REG_AW-1:2];
  assign tf_hit = (req_addr >= OFS_TF_LO) && (req_addr <= OFS_TF_HI) && (req_addr[1:0] == 2'b00);
  assign req_ready = !(tf_hit && slot_full);
  assign accept = req_valid && req_ready;
  assign push = accept && tf_hit;
  assign clr_stat = accept && req_write && (req_addr == OFS_ISTAT) && req_wdata[0];
  assign intr_edge = sync_q[SYNC_STAGES-1] && !sync_q[SYNC_STAGES];
  assign unused_wdata = ^{req_wdata[REG_DW-1:TIME_W]};

  always_comb begin
    push_op.wr   = req_write;
    push_op.cs1  = (tf_off == (OFS_TF_HI - OFS_TF_LO));
    push_op.da   = push_op.cs1 ? DEV_AW'(6) : tf_idx[DEV_AW-1:0];
    push_op.wide = (req_addr == OFS_TF_LO);
    push_op.swap = swap_q;
    if (push_op.wide)
      push_op.data = swap_q ? swap_bytes(req_wdata[DEV_DW-1:0]) : req_wdata[DEV_DW-1:0];
    else
      push_op.data = {{(DEV_DW-8){1'b0}}, req_wdata[7:0]};
  end

  always_comb begin
    rd_val = '0;
    unique case (req_addr)
      OFS_CTRL:  rd_val[0] = en_q;
      OFS_ISTAT: rd_val[0] = stat_q;
      OFS_IMASK: rd_val[0] = mask_q;
      OFS_CFG:   begin rd_val[CFG_WAIT_BIT] = wait_q; rd_val[CFG_SWAP_BIT] = swap_q; end
      OFS_TIME:  rd_val[TIME_W-1:0] = time_q;
      OFS_RDATA: rd_val[DEV_DW-1:0] = rdcap_q;
      OFS_PEND:  begin rd_val[PEND_BUSY_BIT] = busy; rd_val[PEND_SLOT_BIT] = slot_full; end
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; wait_q <= 1'b0; swap_q <= 1'b0; mask_q <= 1'b0; stat_q <= 1'b0;
      time_q <= '0; rdcap_q <= '0; sync_q <= '0;
      rsp_valid <= 1'b0; rsp_data <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-1:0], intrq};
      rsp_valid <= accept && !req_write;
      rsp_data  <= (accept && !req_write) ? rd_val : '0;
      if (cap_fire) rdcap_q <= cap_word;
      if (intr_edge) stat_q <= 1'b1;
      else if (clr_stat) stat_q <= 1'b0;
      if (accept && req_write) begin
        unique case (req_addr)
          OFS_CTRL:  en_q <= req_wdata[0];
          OFS_IMASK: mask_q <= req_wdata[0];
          OFS_CFG:   begin wait_q <= req_wdata[CFG_WAIT_BIT]; swap_q <= req_wdata[CFG_SWAP_BIT]; end
          OFS_TIME:  time_q <= req_wdata[TIME_W-1:0];
          default:   ;
        endcase
      end
    end
  end

  assign ctrl_en  = en_q;
  assign cfg_wait = wait_q;
  assign timing   = time_q;
  assign irq      = stat_q && mask_q;

  // R11: a clear without a coincident edge leaves the status bit low
  a_r11_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stat && !intr_edge) |=> !irq);
  // R2: every accepted read produces a response on the next cycle
  a_r2_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);
endmodule

// File: rtl/pata_pio_slot.sv
module pata_pio_slot
  import pata_pio_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    push,
  input  dev_op_t push_op,
  input  logic    take,
  output logic    full,
  output dev_op_t op
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      op   <= '0;
    end else if (push) begin
      full <= 1'b1;
      op   <= push_op;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  // R10: the one-entry slot is never written while occupied
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
endmodule

// File: rtl/pata_pio_cycle.sv
module pata_pio_cycle
  import pata_pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wait_en,
  input  logic [TIME_W-1:0] timing,
  input  logic              slot_full,
  input  dev_op_t           slot_op,
  output logic              take,
  output logic              busy,
  output logic              cap_fire,
  output logic [DEV_DW-1:0] cap_word,
  output logic              ata_cs0_n,
  output logic              ata_cs1_n,
  output logic [DEV_AW-1:0] ata_da,
  output logic              ata_dior_n,
  output logic              ata_diow_n,
  output logic [DEV_DW-1:0] ata_dd_out,
  output logic              ata_dd_oe,
  input  logic [DEV_DW-1:0] ata_dd_in,
  input  logic              ata_iordy
);
  phase_t           ph;
  logic [CNT_W-1:0] cnt, tset_q, tact_q, trec_q;
  logic [CNT_W-1:0] n_set, n_act, n_rec;
  logic             wait_q, strobe_done, recov_done;
  dev_op_t          cur;

  assign n_set = (timing[SET_W-1:0] == '0) ? CNT_W'(1) : CNT_W'(timing[SET_W-1:0]);
  assign n_act = (timing[SET_W+ACT_W-1:SET_W] == '0) ? CNT_W'(1) : CNT_W'(timing[SET_W+ACT_W-1:SET_W]);
  assign n_rec = (timing[TIME_W-1:SET_W+ACT_W] == '0) ? CNT_W'(1) : CNT_W'(timing[TIME_W-1:SET_W+ACT_W]);

  assign strobe_done = (ph == PH_STROBE) && (cnt >= tact_q) && (!wait_q || ata_iordy);
  assign recov_done  = (ph == PH_RECOV) && (cnt >= trec_q);
  assign take        = slot_full && en && ((ph == PH_IDLE) || recov_done);
  assign busy        = (ph != PH_IDLE);
  assign cap_fire    = strobe_done && !cur.wr;
  assign cap_word    = !cur.wide ? {{(DEV_DW-8){1'b0}}, ata_dd_in[7:0]}
                     : (cur.swap ? swap_bytes(ata_dd_in) : ata_dd_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; cnt <= '0; cur <= '0; wait_q <= 1'b0;
      tset_q <= '0; tact_q <= '0; trec_q <= '0;
    end else begin
      unique case (ph)
        PH_SETUP:  if (cnt >= tset_q) begin ph <= PH_STROBE; cnt <= CNT_W'(1); end
                   else cnt <= cnt + 1'b1;
        PH_STROBE: if (strobe_done) begin ph <= PH_RECOV; cnt <= CNT_W'(1); end
                   else if (cnt < tact_q) cnt <= cnt + 1'b1;
        PH_RECOV:  if (recov_done) ph <= PH_IDLE;
                   else cnt <= cnt + 1'b1;
        default:   ;
      endcase
      if (take) begin
        ph <= PH_SETUP; cnt <= CNT_W'(1); cur <= slot_op; wait_q <= wait_en;
        tset_q <= n_set; tact_q <= n_act; trec_q <= n_rec;
      end
    end
  end

  assign ata_cs0_n  = !(busy && !cur.cs1);
  assign ata_cs1_n  = !(busy && cur.cs1);
  assign ata_da     = busy ? cur.da : '0;
  assign ata_dior_n = !((ph == PH_STROBE) && !cur.wr);
  assign ata_diow_n = !((ph == PH_STROBE) && cur.wr);
  assign ata_dd_oe  = busy && cur.wr;
  assign ata_dd_out = ata_dd_oe ? cur.data : '0;

  // R8: with the interface disabled an idle engine stays idle
  a_r8_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_IDLE && !en) |=> (ph == PH_IDLE));
  // R5: an enabled wait state holds the strobe while IORDY is low
  a_r5_iordy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_STROBE && wait_q && !ata_iordy) |=> (ph == PH_STROBE));
  // R3: strobes only appear under an active chip select
  a_r3_strobe_in_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!ata_dior_n || !ata_diow_n) |-> (!ata_cs0_n || !ata_cs1_n));
  // R3: address does not move between strobe and the following cycle of the same access
  a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_STROBE) |=> $stable(ata_da));
endmodule

// File: rtl/pata_pio_host.sv
module pata_pio_host
  import pata_pio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [7:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_data,
  output logic        ata_cs0_n,
  output logic        ata_cs1_n,
  output logic [2:0]  ata_da,
  output logic        ata_dior_n,
  output logic        ata_diow_n,
  output logic [15:0] ata_dd_out,
  output logic        ata_dd_oe,
  input  logic [15:0] ata_dd_in,
  input  logic        ata_iordy,
  input  logic        ata_intrq,
  output logic        irq
);
  logic              slot_full, push, take, busy, cap_fire, ctrl_en, cfg_wait;
  dev_op_t           push_op, slot_op;
  logic [TIME_W-1:0] timing;
  logic [DEV_DW-1:0] cap_word;

  pata_pio_regs #(.SYNC_STAGES(2)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .slot_full(slot_full), .push(push), .push_op(push_op),
    .ctrl_en(ctrl_en), .cfg_wait(cfg_wait), .timing(timing),
    .busy(busy), .cap_fire(cap_fire), .cap_word(cap_word),
    .intrq(ata_intrq), .irq(irq)
  );

  pata_pio_slot u_slot (
    .clk(clk), .rst_n(rst_n), .push(push), .push_op(push_op),
    .take(take), .full(slot_full), .op(slot_op)
  );

  pata_pio_cycle u_cycle (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .wait_en(cfg_wait), .timing(timing),
    .slot_full(slot_full), .slot_op(slot_op), .take(take), .busy(busy),
    .cap_fire(cap_fire), .cap_word(cap_word),
    .ata_cs0_n(ata_cs0_n), .ata_cs1_n(ata_cs1_n), .ata_da(ata_da),
    .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n),
    .ata_dd_out(ata_dd_out), .ata_dd_oe(ata_dd_oe),
    .ata_dd_in(ata_dd_in), .ata_iordy(ata_iordy)
  );
endmodule

// File: tb/sim_pata_pio_host.sv
`timescale 1ns/1ps
module sim_pata_pio_host;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_data;
  logic cs0_n, cs1_n, dior_n, diow_n, dd_oe, irq;
  logic [2:0] da;
  logic [15:0] dd_out;
  logic [15:0] dev_word = 16'h0000;
  logic iordy = 1'b1, intrq = 1'b0;
  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  pata_pio_host u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ata_cs0_n(cs0_n), .ata_cs1_n(cs1_n), .ata_da(da),
    .ata_dior_n(dior_n), .ata_diow_n(diow_n), .ata_dd_out(dd_out), .ata_dd_oe(dd_oe),
    .ata_dd_in(dev_word), .ata_iordy(iordy), .ata_intrq(intrq), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_en, m_wait, m_swap, m_mask, m_st, m_hv, m_rv;
  bit [2:0] m_sync;
  bit [19:0] m_tim;
  bit [15:0] m_rdcap;
  bit [31:0] m_rdat;
  int m_ph, m_cnt, m_ts, m_ta, m_tr;
  bit m_io;
  bit h_wr, h_cs1, h_wide, h_swap; bit [2:0] h_da; bit [15:0] h_data;
  bit c_wr, c_cs1, c_wide, c_swap; bit [2:0] c_da; bit [15:0] c_data;

  function automatic int tf_slot(input logic [7:0] a);
    case (a)
      8'h54: return 0; 8'h58: return 1; 8'h5C: return 2; 8'h60: return 3;
      8'h64: return 4; 8'h68: return 5; 8'h6C: return 6; 8'h70: return 7;
      8'h74: return 8; default: return -1;
    endcase
  endfunction

  function automatic int atleast1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic bit m_ready_f();
    return !(m_hv && tf_slot(req_addr) >= 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_wait = 0; m_swap = 0; m_mask = 0; m_st = 0; m_hv = 0; m_rv = 0;
      m_sync = 0; m_tim = 0; m_rdcap = 0; m_rdat = 0; m_ph = 0; m_cnt = 0;
      m_ts = 0; m_ta = 0; m_tr = 0; m_io = 0;
      {h_wr, h_cs1, h_wide, h_swap, h_da, h_data} = '0;
      {c_wr, c_cs1, c_wide, c_swap, c_da, c_data} = '0;
    end else begin
      bit acc, launch, edge_seen;
      int slot;
      bit [31:0] rv;
      acc = req_valid && m_ready_f();
      slot = tf_slot(req_addr);
      // response built from pre-edge state
      rv = 0;
      case (req_addr)
        8'h00: rv[0] = m_en;
        8'h10: rv[0] = m_st;
        8'h14: rv[0] = m_mask;
        8'h18: begin rv[1] = m_wait; rv[6] = m_swap; end
        8'h2C: rv[19:0] = m_tim;
        8'h7C: rv[15:0] = m_rdcap;
        8'h84: begin rv[28] = (m_ph != 0); rv[29] = m_hv; end
        default: rv = 0;
      endcase
      m_rv = acc && !req_write;
      m_rdat = m_rv ? rv : 0;
      // interrupt synchroniser
      edge_seen = m_sync[1] && !m_sync[2];
      m_sync = {m_sync[1:0], intrq};
      // engine
      launch = m_hv && m_en && (m_ph == 0 || (m_ph == 3 && m_cnt >= m_tr));
      if (m_ph == 1) begin
        if (m_cnt >= m_ts) begin m_ph = 2; m_cnt = 1; end else m_cnt++;
      end else if (m_ph == 2) begin
        if (m_cnt >= m_ta && (!m_io || iordy)) begin
          if (!c_wr) m_rdcap = !c_wide ? {8'h00, dev_word[7:0]}
                             : (c_swap ? {dev_word[7:0], dev_word[15:8]} : dev_word);
          m_ph = 3; m_cnt = 1;
        end else if (m_cnt < m_ta) m_cnt++;
      end else if (m_ph == 3) begin
        if (m_cnt >= m_tr) m_ph = 0; else m_cnt++;
      end
      if (launch) begin
        m_ph = 1; m_cnt = 1; m_hv = 0; m_io = m_wait;
        m_ts = atleast1(m_tim[3:0]); m_ta = atleast1(m_tim[11:4]); m_tr = atleast1(m_tim[19:12]);
        {c_wr, c_cs1, c_wide, c_swap, c_da, c_data} = {h_wr, h_cs1, h_wide, h_swap, h_da, h_data};
      end
      // holding slot
      if (acc && slot >= 0) begin
        m_hv = 1; h_wr = req_write; h_cs1 = (slot == 8); h_da = (slot == 8) ? 3'd6 : 3'(slot);
        h_wide = (slot == 0); h_swap = m_swap;
        h_data = (slot != 0) ? {8'h00, req_wdata[7:0]}
               : (m_swap ? {req_wdata[7:0], req_wdata[15:8]} : req_wdata[15:0]);
      end
      // interrupt status
      if (edge_seen) m_st = 1;
      else if (acc && req_write && req_addr == 8'h10 && req_wdata[0]) m_st = 0;
      // register writes
      if (acc && req_write) begin
        case (req_addr)
          8'h00: m_en = req_wdata[0];
          8'h14: m_mask = req_wdata[0];
          8'h18: begin m_wait = req_wdata[1]; m_swap = req_wdata[6]; end
          8'h2C: m_tim = req_wdata[19:0];
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit busy_m, e_oe;
      busy_m = (m_ph != 0);
      e_oe = busy_m && c_wr;
      chk(req_ready === m_ready_f(), "R2 req_ready", req_ready, m_ready_f());
      chk(rsp_valid === m_rv, "R2 rsp_valid", rsp_valid, m_rv);
      if (m_rv) chk(rsp_data === m_rdat, "R7/R9 rsp_data", rsp_data, m_rdat);
      chk(cs0_n === !(busy_m && !c_cs1), "R3 cs0_n", cs0_n, !(busy_m && !c_cs1));
      chk(cs1_n === !(busy_m && c_cs1), "R3 cs1_n", cs1_n, !(busy_m && c_cs1));
      chk(da === (busy_m ? c_da : 3'd0), "R3 da", da, busy_m ? c_da : 3'd0);
      chk(dior_n === !(m_ph == 2 && !c_wr), "R4 dior_n", dior_n, !(m_ph == 2 && !c_wr));
      chk(diow_n === !(m_ph == 2 && c_wr), "R4 diow_n", diow_n, !(m_ph == 2 && c_wr));
      chk(dd_oe === e_oe, "R6 dd_oe", dd_oe, e_oe);
      chk(dd_out === (e_oe ? c_data : 16'h0), "R6 dd_out", dd_out, e_oe ? c_data : 16'h0);
      chk(irq === (m_st && m_mask), "R11 irq", irq, m_st && m_mask);
    end
  end

  // gap monitor for back-to-back cycles
  bit mon_on = 0, prev_cs0 = 1;
  int cs_rises = 0, w_strobes = 0;
  bit prev_w = 1;
  always @(negedge clk) begin
    if (mon_on) begin
      if (!prev_cs0 && cs0_n) cs_rises++;
      if (prev_w && !diow_n) w_strobes++;
    end
    prev_cs0 = cs0_n; prev_w = diow_n;
  end

  // ---------------- stimulus ----------------
  task automatic bus(input bit w, input logic [7:0] a, input logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    r = rsp_data;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] r;
    bus(1'b1, a, d, r);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] r);
    bus(1'b0, a, 32'h0, r);
  endtask

  task automatic drain(input string tag);
    logic [31:0] r;
    int n = 0;
    do begin rd(8'h84, r); n++; end while (r[29:28] != 0 && n < 300);
    chk(r == 0, tag, r, 32'h0);
  endtask

  initial begin : watchdog
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    chk(1'b0, "watchdog", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cs0_n && cs1_n && dior_n && diow_n && !dd_oe && !irq && req_ready, "R1 pins idle",
        {cs0_n, cs1_n, dior_n, diow_n, dd_oe, irq, req_ready}, 7'b1111001);
    rd(8'h00, r); chk(r == 0, "R1 ctrl", r, 0);
    rd(8'h2C, r); chk(r == 0, "R1 timing", r, 0);
    rd(8'h84, r); chk(r == 0, "R1 R9 pending", r, 0);
    // R4 timing setup=2 strobe=4 recovery=3
    wr(8'h2C, 32'hFFF03042);
    rd(8'h2C, r); chk(r == 32'h00003042, "R4 timing readback", r, 32'h3042);
    // R8 disabled: access held, nothing on the bus
    wr(8'h5C, 32'h000000A5);
    repeat (10) @(negedge clk);
    chk(cs0_n && diow_n, "R8 no cycle while disabled", {cs0_n, diow_n}, 2'b11);
    rd(8'h84, r); chk(r == 32'h20000000, "R9 slot occupied", r, 32'h20000000);
    wr(8'h00, 32'h1);
    drain("R8 held access completes");
    // R6 data window write, plain then swapped
    wr(8'h54, 32'h1234BEEF); drain("R6 plain drain");
    wr(8'h18, 32'h40);
    wr(8'h54, 32'h0000BEEF); drain("R6 swap drain");
    // R7 deferred reads
    dev_word = 16'h1234;
    rd(8'h54, r); chk(r == 0, "R7 tf read returns zero", r, 0);
    drain("R7 read drain");
    rd(8'h7C, r); chk(r == 32'h3412, "R7 swapped data capture", r, 32'h3412);
    wr(8'h18, 32'h0);
    rd(8'h70, r); drain("R7 status drain");
    rd(8'h7C, r); chk(r == 32'h34, "R7 tf low byte only", r, 32'h34);
    // R10 back-to-back without gap
    cs_rises = 0; w_strobes = 0; mon_on = 1;
    wr(8'h60, 32'h11); wr(8'h64, 32'h22);
    repeat (40) @(negedge clk);
    mon_on = 0;
    chk(cs_rises == 1, "R10 no idle gap", cs_rises, 1);
    chk(w_strobes == 2, "R10 two strobes", w_strobes, 2);
    // R5 wait states
    wr(8'h18, 32'h2);
    iordy = 1'b0;
    wr(8'h68, 32'h33);
    repeat (20) @(negedge clk);
    chk(diow_n == 1'b0, "R5 strobe stretched", diow_n, 0);
    iordy = 1'b1;
    drain("R5 wait released");
    wr(8'h18, 32'h0);
    iordy = 1'b0;
    wr(8'h6C, 32'h44);
    repeat (16) @(negedge clk);
    chk(cs0_n && diow_n, "R5 iordy ignored when off", {cs0_n, diow_n}, 2'b11);
    iordy = 1'b1;
    // R3 secondary select
    wr(8'h74, 32'h0E);
    repeat (2) @(negedge clk);
    chk(!cs1_n && cs0_n && da == 3'd6, "R3 control window select", {cs1_n, cs0_n, da}, {2'b01, 3'd6});
    drain("R3 drain");
    // R4 zero fields count as one
    wr(8'h2C, 32'h0);
    wr(8'h58, 32'h77); drain("R4 zero timing drain");
    // R11 interrupt
    wr(8'h14, 32'h1);
    intrq = 1'b1; repeat (5) @(negedge clk);
    chk(irq == 1'b1, "R11 irq on edge", irq, 1);
    intrq = 1'b0;
    wr(8'h10, 32'h1);
    chk(irq == 1'b0, "R11 w1c clears", irq, 0);
    rd(8'h10, r); chk(r == 0, "R11 status cleared", r, 0);
    wr(8'h14, 32'h0);
    intrq = 1'b1; repeat (5) @(negedge clk); intrq = 1'b0;
    chk(irq == 1'b0, "R11 masked", irq, 0);
    rd(8'h10, r); chk(r == 1, "R11 status set under mask", r, 1);
    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule